// File: doc/BRIEF.md
# SPI Target Buffer Event Controller

This block is the front end of an SPI target (slave) port. A host clocks bytes in on MOSI, most significant bit first, in SPI mode 0; each completed byte lands in a 128-entry circular input buffer. On MISO the block returns bytes from a 128-entry output buffer, which the local core fills ahead of time. Chip select and the serial clock are brought into the system clock domain through two-flop synchronizers, and all events are detected there.

Next to the data path, the block raises byte-level events. There are two fill-level events: a primary one (half full by default) and a secondary one whose 6-bit threshold is meant for a header length. There are also events for chip-select falling and rising edges, and an end-of-receive event. The core reaches the configuration, enable and status registers, and both buffers, through a simple register port. The single interrupt line is high whenever a pending status bit has its enable bit set. The rising-edge event fires on every deassertion, even when the host sent no clock. Software can therefore detect an aborted or glitched select without depending on the end-of-receive event, which needs clock activity.

Register map: 0x01 primary level (bits 6:0 level, bit 7 disable, reset 0x40), 0x02 secondary level (bits 5:0 threshold, bit 7 disable, bit 6 reads 0, reset 0x88), 0x03 status, 0x04 enable, 0x05 info (bit 7 busy, bits 6:0 bytes received since select). In the status and enable registers: bit 0 is secondary level, bit 1 is select rising edge, bit 2 is select falling edge, bit 3 is primary level and bit 4 is end-of-receive. Addresses 0x80–0xFF write the output buffer and read the input buffer, indexed by the low 7 address bits.

Top module: `spi_tgt_evt`

## Requirements
- R1: After reset the primary level register reads 0x40, the secondary level register 0x88, status and enable 0x00, info 0x00, and irq is low.
- R2: Each byte the host shifts in (MSB first, sampled on SCK rising) is stored at input index = bytes received since the last select assertion. That count starts at 0 on each assertion, wraps from 127 to 0, and input index n reads back at address 0x80+n.
- R3: On MISO the block presents output-buffer bytes MSB first, valid at each SCK rising edge. The bytes come from output index 0 upward (wrapping at 128) from each select assertion; a write to 0x80+n loads output index n.
- R4: Status bit 3 sets when a completed byte brings the received count to the primary level (level 0 means 128), unless bit 7 of the primary level register is 1.
- R5: Status bit 0 sets when a completed byte brings the received count to the secondary threshold, unless bit 7 of the secondary level register is 1. Writing the threshold while it is disabled never sets bit 0.
- R6: Status bit 2 sets on every select assertion and status bit 1 on every deassertion, including selects with no SCK activity.
- R7: Status bit 4 sets on deassertion only if at least one SCK edge occurred during that select.
- R8: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R9: irq is high exactly when some status bit and the matching enable bit are both 1.
- R10: Info bit 7 reads 1 while select is asserted and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select from host, active low |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | input | 8 | Register port address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of enabled pending events |

## Verification
The assertions assume the host keeps each SCK phase and each select interval several system clocks long, so that every synchronized edge is seen and a byte completion never falls in the same cycle as a select edge. The bench keeps each SCK half period at ten system clocks, lets MOSI change only while SCK is low, and places all host edges on falling system-clock edges. Register writes land between bytes and never on a synchronized SPI edge.

// File: rtl/spi_tgt_evt.sv
module spi_tgt_evt #(
  parameter int DEPTH    = 128,
  parameter int AW       = 8,
  parameter logic [7:0] LVL1_RST = 8'h40,
  parameter logic [7:0] LVL2_RST = 8'h88
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_csn,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wen,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [AW-1:0] A_LVL1 = AW'(1);
  localparam logic [AW-1:0] A_LVL2 = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_ENA  = AW'(4);
  localparam logic [AW-1:0] A_INFO = AW'(5);

  logic [2:0] csn_q, sck_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [PW-1:0] in_ptr, out_ptr;
  logic sck_seen;
  logic [7:0] lvl1;
  logic lvl2_dis;
  logic [5:0] lvl2_thr;
  logic [4:0] stat, ena;
  logic [7:0] ibuf [DEPTH];
  logic [7:0] obuf [DEPTH];

  wire cs_act    = ~csn_q[1];
  wire cs_fall   = csn_q[2] & ~csn_q[1];
  wire cs_rise   = ~csn_q[2] & csn_q[1];
  wire sck_rise  = cs_act & ~sck_q[2] & sck_q[1];
  wire sck_fall  = cs_act & sck_q[2] & ~sck_q[1];
  wire byte_done = sck_rise && (bit_cnt == 3'd7);
  wire [7:0] rx_byte = {shreg, mosi_q[1]};
  wire [PW-1:0] ptr_nxt = in_ptr + 1'b1;
  wire buf_sel = reg_addr[AW-1];

  wire ev_l1  = byte_done && !lvl1[7] && (ptr_nxt == lvl1[PW-1:0]);
  wire ev_l2  = byte_done && !lvl2_dis && (ptr_nxt == PW'(lvl2_thr));
  wire ev_eor = cs_rise && sck_seen;
  wire [4:0] ev_set = {ev_eor, ev_l1, cs_fall, cs_rise, ev_l2};
  wire [4:0] w1c = (reg_wen && reg_addr == A_STAT) ? reg_wdata[4:0] : 5'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      csn_q  <= 3'b111;
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
    end else begin
      csn_q  <= {csn_q[1:0], spi_csn};
      sck_q  <= {sck_q[1:0], spi_sck};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      in_ptr   <= '0;
      out_ptr  <= '0;
      sck_seen <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt  <= '0;
      in_ptr   <= '0;
      out_ptr  <= '0;
      sck_seen <= 1'b0;
    end else if (sck_rise) begin
      shreg    <= rx_byte[6:0];
      bit_cnt  <= bit_cnt + 1'b1;
      sck_seen <= 1'b1;
      if (byte_done) begin
        in_ptr  <= ptr_nxt;
        out_ptr <= out_ptr + 1'b1;
      end
    end else if (sck_fall) begin
      sck_seen <= 1'b1;
    end

  always_ff @(posedge clk) begin
    if (byte_done) ibuf[in_ptr] <= rx_byte;
    if (reg_wen && buf_sel) obuf[reg_addr[PW-1:0]] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl1     <= LVL1_RST;
      lvl2_dis <= LVL2_RST[7];
      lvl2_thr <= LVL2_RST[5:0];
      ena      <= '0;
      stat     <= '0;
    end else begin
      stat <= (stat & ~w1c) | ev_set;
      if (reg_wen && reg_addr == A_LVL1) lvl1 <= reg_wdata;
      if (reg_wen && reg_addr == A_LVL2) begin
        lvl2_dis <= reg_wdata[7];
        lvl2_thr <= reg_wdata[5:0];
      end
      if (reg_wen && reg_addr == A_ENA) ena <= reg_wdata[4:0];
    end

  assign spi_miso = obuf[out_ptr][~bit_cnt];
  assign irq = |(stat & ena);

  always_comb begin
    reg_rdata = 8'h00;
    if (buf_sel) reg_rdata = ibuf[reg_addr[PW-1:0]];
    else case (reg_addr)
      A_LVL1:  reg_rdata = lvl1;
      A_LVL2:  reg_rdata = {lvl2_dis, 1'b0, lvl2_thr};
      A_STAT:  reg_rdata = {3'b000, stat};
      A_ENA:   reg_rdata = {3'b000, ena};
      A_INFO:  reg_rdata = {cs_act, 7'(in_ptr)};
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r2_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && in_ptr == PW'(DEPTH-1) && !cs_fall |=> in_ptr == '0);
  a_r2_ptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> in_ptr == '0 && bit_cnt == '0);
  a_r5_no_l2_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    lvl2_dis && !stat[0] |=> !stat[0]);
  a_r6_rise_always: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> stat[1]);
  a_r7_eor_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[4]) |-> $past(cs_rise));
endmodule

// File: tb/tb_spi_tgt_evt.sv
module tb_spi_tgt_evt;
  localparam time HALF = 40ns;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, irq;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic reg_wen = 1'b0;
  int compared = 0, mismatched = 0;
  logic [7:0] miso_q[$];
  logic [7:0] mbits = 8'h00;
  int mcnt = 0;

  always #2ns clk = ~clk;

  spi_tgt_evt dut (.clk, .rst_n, .spi_csn, .spi_sck, .spi_mosi, .spi_miso,
                   .reg_addr, .reg_wen, .reg_wdata, .reg_rdata, .irq);

  function automatic logic [7:0] txd(int k);
    return 8'(8'hC3 ^ (k * 37));
  endfunction
  function automatic logic [7:0] opat(int k);
    return 8'((k % 128) ^ 8'h5A);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic chk_reg(input logic [7:0] a, input logic [7:0] e, input string req);
    @(negedge clk); reg_addr = a; #1ns;
    compared++;
    if (reg_rdata !== e) begin
      mismatched++;
      $display("FAIL %s reg %h: got %h expected %h", req, a, reg_rdata, e);
    end
  endtask

  task automatic chk_irq(input logic e, input string req);
    @(negedge clk); #1ns;
    compared++;
    if (irq !== e) begin
      mismatched++;
      $display("FAIL %s irq: got %b expected %b", req, irq, e);
    end
  endtask

  task automatic cs_low();
    @(negedge clk); spi_csn = 1'b0; #HALF;
  endtask
  task automatic cs_high();
    @(negedge clk); spi_sck = 1'b0; #HALF; spi_csn = 1'b1; #HALF;
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] exp_out);
    miso_q.push_back(exp_out);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i]; #HALF;
      spi_sck = 1'b1; #HALF;
      spi_sck = 1'b0;
    end
  endtask

  // scoreboard monitor: R3 MISO bytes against queued expectations
  always @(posedge spi_sck) if (!spi_csn) begin
    mbits = {mbits[6:0], spi_miso};
    mcnt++;
    if (mcnt == 8) begin
      mcnt = 0;
      compared++;
      if (miso_q.size() == 0) begin
        mismatched++;
        $display("FAIL R3 miso: got %h expected none", mbits);
      end else begin
        logic [7:0] e;
        e = miso_q.pop_front();
        if (mbits !== e) begin
          mismatched++;
          $display("FAIL R3 miso: got %h expected %h", mbits, e);
        end
      end
    end
  end
  always @(posedge spi_csn) mcnt = 0;

  initial begin
    #600us;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_reg(8'h01, 8'h40, "R1");
    chk_reg(8'h02, 8'h88, "R1");
    chk_reg(8'h03, 8'h00, "R1");
    chk_reg(8'h04, 8'h00, "R1");
    chk_reg(8'h05, 8'h00, "R1");
    chk_irq(1'b0, "R1");

    for (int i = 0; i < 128; i++) wr(8'(8'h80 + i), opat(i));
    wr(8'h04, 8'h1F);
    wr(8'h01, 8'h06);
    wr(8'h02, 8'h04);

    // transaction A: thresholds 4 and 6
    cs_low();
    chk_reg(8'h03, 8'h04, "R6");
    chk_reg(8'h05, 8'h80, "R10");
    for (int k = 0; k < 4; k++) send(txd(k), opat(k));
    chk_reg(8'h03, 8'h05, "R5");
    for (int k = 4; k < 6; k++) send(txd(k), opat(k));
    chk_reg(8'h03, 8'h0D, "R4");
    cs_high();
    chk_reg(8'h03, 8'h1F, "R7");
    chk_reg(8'h05, 8'h06, "R10");
    chk_irq(1'b1, "R9");
    for (int k = 0; k < 6; k++) chk_reg(8'(8'h80 + k), txd(k), "R2");

    // write-one-to-clear and irq masking
    wr(8'h03, 8'h00);
    chk_reg(8'h03, 8'h1F, "R8");
    wr(8'h03, 8'h11);
    chk_reg(8'h03, 8'h0E, "R8");
    wr(8'h04, 8'h00);
    chk_irq(1'b0, "R9");
    wr(8'h04, 8'h02);
    chk_irq(1'b1, "R9");
    wr(8'h03, 8'h0E);
    chk_reg(8'h03, 8'h00, "R8");
    chk_irq(1'b0, "R9");

    // select pulse with no clocks
    cs_low();
    cs_high();
    chk_reg(8'h03, 8'h06, "R7");
    chk_reg(8'h05, 8'h00, "R10");
    wr(8'h03, 8'h1F);

    // both levels disabled; threshold rewritten while disabled
    wr(8'h01, 8'h86);
    wr(8'h02, 8'h82);
    cs_low();
    for (int k = 0; k < 3; k++) send(txd(k + 10), opat(k));
    wr(8'h02, 8'h83);
    chk_reg(8'h02, 8'h83, "R5");
    chk_reg(8'h03, 8'h04, "R5");
    for (int k = 3; k < 6; k++) send(txd(k + 10), opat(k));
    cs_high();
    chk_reg(8'h03, 8'h16, "R4");
    wr(8'h03, 8'h1F);

    // wrap: level 0 means 128
    wr(8'h01, 8'h00);
    wr(8'h02, 8'h80);
    cs_low();
    for (int k = 0; k < 127; k++) send(txd(k + 50), opat(k));
    chk_reg(8'h03, 8'h04, "R4");
    for (int k = 127; k < 130; k++) send(txd(k + 50), opat(k));
    chk_reg(8'h03, 8'h0C, "R4");
    chk_reg(8'h05, 8'h82, "R2");
    cs_high();
    chk_reg(8'h03, 8'h1E, "R6");
    chk_reg(8'h80, txd(178), "R2");
    chk_reg(8'h81, txd(179), "R2");
    chk_reg(8'h82, txd(52), "R2");
    chk_reg(8'hFF, txd(177), "R2");

    compared++;
    if (miso_q.size() != 0) begin
      mismatched++;
      $display("FAIL R3 miso queue: got %0d left expected 0", miso_q.size());
    end
    summary();
    $finish;
  end
endmodule